// File: doc/BRIEF.md
# Flash Block Protection Gate

This block sits between a flash command front end and the array controller. It decides whether a program or erase aimed at one flash block may go ahead. The inputs to that decision are a vector of stored per-block protection bits, a hardware write-protect pin, a temporary-unprotect condition, and a boot-location configuration chosen at build time. Voltage levels on the write-protect and reset pins reach the block already decoded into two-bit level codes. An elevated level on the reset pin means temporary unprotect. An elevated level on the write-protect pin means the device is in unlock-bypass mode.

The gate also classifies reads. A read aimed at the bank that holds a running program or erase gets a status indication. A read aimed at the other bank gets array data, which lets one bank be read while the other is busy. The block also filters pulses on the reset pin. A low level that lasts for the minimum time is a hardware reset. After release, every bus request is held off until a recovery interval has elapsed. A ready flag reports whether the array is free.

Each request is answered with one result code, registered one clock after the request is sampled.

Top module: `fpg_prot_gate`

## Requirements
- R1: While the write-protect level is low (code 2'b00), a write request to one of the two outermost boot blocks yields result DROP (3'd4). This holds whatever the stored bit of that block and whether temporary unprotect is active.
- R2: While the write-protect level is high (2'b01) or elevated (2'b10 or 2'b11), the two outermost boot blocks follow their stored protection bit, exactly like the other blocks.
- R3: While the reset level is elevated (2'b10 or 2'b11), a write to any block outside the rule of R1 yields GO (3'd3), even if its stored protection bit is 1.
- R4: When no temporary unprotect is active, a write to a block whose stored bit is 1 yields DROP (3'd4). A write to a block whose stored bit is 0 yields GO (3'd3).
- R5: With BOOT_TOP=1, the outermost boot blocks are NB_BLOCKS-1 and NB_BLOCKS-2, and the small bank (bank 0) is the top quarter of the blocks. With BOOT_TOP=0, the outermost boot blocks are 0 and 1, and bank 0 is the bottom quarter. All other blocks belong to bank 1.
- R6: `bypass_o` is 1 in the cycle after an elevated write-protect level is sampled. It is 0 in the cycle after a low or high level is sampled.
- R7: A reset level of low (2'b00) sampled on RST_MIN_CYC consecutive clock edges starts a hardware reset: after that edge `ready_o` is 0. A shorter low pulse has no effect on `ready_o` or on request results.
- R8: After a hardware reset is released, a request sampled on the releasing edge or on any of the next RST_RECOVER_CYC edges yields HOLD (3'd5). `ready_o` returns to 1 after RST_RECOVER_CYC edges past the release.
- R9: `ready_o` is 0 in the cycle after the engine is sampled busy and not suspended. It is 1 when the engine is idle or suspended, provided no reset hold is in progress.
- R10: A read request yields STATUS (3'd2) when the engine was busy and not suspended in the previous cycle and its bank (`eng_bank_i`, 0 = small bank) equals the bank of the requested block. Otherwise a read yields ARRAY (3'd1).
- R11: The result for a request sampled at a clock edge appears on `res_code_o` right after that edge. A cycle with no request shows NONE (3'd0), and this is also the value after system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| prot_bits_i | input | NB_BLOCKS | Stored protection bit per block, 1 = protected |
| wp_code_i | input | 2 | Write-protect level: 00 low, 01 high, 1x elevated |
| rp_code_i | input | 2 | Reset pin level: 00 low, 01 high, 1x elevated |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = program/erase, 0 = read |
| req_block_i | input | BLK_W | Target block index |
| eng_busy_i | input | 1 | Program/erase engine running |
| eng_suspend_i | input | 1 | Running erase is suspended |
| eng_bank_i | input | 1 | Bank of the running operation |
| res_code_o | output | 3 | Result: 0 none, 1 array, 2 status, 3 go, 4 drop, 5 hold |
| ready_o | output | 1 | 1 = array ready, 0 = busy or in reset hold |
| bypass_o | output | 1 | Unlock-bypass mode active |

## Verification
The write path is swept over every block, under both an all-ones and an all-zeros protection vector, for each of the three write-protect levels, with and without temporary unprotect. Two instances with opposite boot locations run side by side. This separates the write-protect override from the stored bits and from temporary unprotect, and it shows that the boot-block and bank boundaries move with the configuration. A mixed protection pattern confirms that each block's own bit is chosen. Reads are swept over every combination of engine busy, suspend and bank, which shows whether status comes back only from the busy bank. Reset pulses one cycle short of the minimum and exactly at the minimum are applied. The hold window is then counted edge by edge to pin down its length.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef enum logic [2:0] {
        RES_NONE   = 3'd0,
        RES_ARRAY  = 3'd1,
        RES_STATUS = 3'd2,
        RES_GO     = 3'd3,
        RES_DROP   = 3'd4,
        RES_HOLD   = 3'd5
    } res_e;

    localparam int unsigned LVL_W = 2;

endpackage

// File: rtl/fpg_level_dec.sv
// Turns a two-bit pin level code into the two conditions the gate uses.
module fpg_level_dec
    import fpg_pkg::*;
(
    input  logic [LVL_W-1:0] code_i,
    output logic             low_o,
    output logic             elev_o
);
    // 00 = logic low, 01 = logic high, 1x = elevated voltage
    assign low_o  = (code_i == 2'b00);
    assign elev_o = code_i[1];
endmodule

// File: rtl/fpg_block_map.sv
// Maps a block index to its boot-zone and bank membership.
module fpg_block_map #(
    parameter int unsigned NB_BLOCKS = 16,
    parameter bit          BOOT_TOP  = 1'b1,
    parameter int unsigned BLK_W     = $clog2(NB_BLOCKS)
) (
    input  logic [BLK_W-1:0] blk_i,
    output logic             outer_o,
    output logic             bank_o
);
    localparam int unsigned QUARTER = NB_BLOCKS / 4;

    generate
        if (BOOT_TOP) begin : g_top
            assign outer_o = (blk_i >= BLK_W'(NB_BLOCKS - 2));
            assign bank_o  = (blk_i >= BLK_W'(NB_BLOCKS - QUARTER)) ? 1'b0 : 1'b1;
        end else begin : g_bottom
            assign outer_o = (blk_i < BLK_W'(2));
            assign bank_o  = (blk_i < BLK_W'(QUARTER)) ? 1'b0 : 1'b1;
        end
    endgenerate
endmodule

// File: rtl/fpg_reset_seq.sv
// Filters low pulses on the reset pin and produces the post-reset hold.
module fpg_reset_seq #(
    parameter int unsigned RST_MIN_CYC     = 8,
    parameter int unsigned RST_RECOVER_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rp_low_i,
    output logic hold_o
);
    localparam int unsigned CNT_W = $clog2(RST_MIN_CYC + 1);
    localparam int unsigned REC_W = $clog2(RST_RECOVER_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RST_MIN_CYC);
    localparam logic [REC_W-1:0] REC_LEN = REC_W'(RST_RECOVER_CYC);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [REC_W-1:0] rec;
    } seq_t;

    seq_t st_d, st_q;
    logic armed;

    assign armed  = (st_q.cnt == CNT_MAX);
    assign hold_o = armed || (st_q.rec != '0);

    always_comb begin
        st_d = st_q;
        if (st_q.rec != '0) begin
            st_d.rec = st_q.rec - REC_W'(1);
        end
        if (rp_low_i) begin
            if (!armed) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            st_d.cnt = '0;
            if (armed) begin
                st_d.rec = REC_LEN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    hold_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_o) |-> $past(rp_low_i))
        else $error("hold started without a low reset level");

    // R8
    recover_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rec != '0) && !armed |=> st_q.rec == $past(st_q.rec) - REC_W'(1))
        else $error("recovery counter did not step down");
endmodule

// File: rtl/fpg_prot_gate.sv
module fpg_prot_gate
    import fpg_pkg::*;
#(
    parameter int unsigned NB_BLOCKS       = 16,
    parameter bit          BOOT_TOP        = 1'b1,
    parameter int unsigned RST_MIN_CYC     = 8,
    parameter int unsigned RST_RECOVER_CYC = 12,
    parameter int unsigned BLK_W           = $clog2(NB_BLOCKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NB_BLOCKS-1:0] prot_bits_i,
    input  logic [1:0]           wp_code_i,
    input  logic [1:0]           rp_code_i,
    input  logic                 req_valid_i,
    input  logic                 req_write_i,
    input  logic [BLK_W-1:0]     req_block_i,
    input  logic                 eng_busy_i,
    input  logic                 eng_suspend_i,
    input  logic                 eng_bank_i,
    output logic [2:0]           res_code_o,
    output logic                 ready_o,
    output logic                 bypass_o
);
    typedef struct packed {
        res_e res;
        logic busy;
        logic bank;
        logic bypass;
    } gate_t;

    gate_t st_d, st_q;

    logic wp_low, wp_elev, rp_low, rp_elev;
    logic blk_outer, blk_bank, rst_hold;
    logic blk_prot;

    fpg_level_dec u_wp_dec (.code_i(wp_code_i), .low_o(wp_low), .elev_o(wp_elev));
    fpg_level_dec u_rp_dec (.code_i(rp_code_i), .low_o(rp_low), .elev_o(rp_elev));

    fpg_block_map #(
        .NB_BLOCKS(NB_BLOCKS), .BOOT_TOP(BOOT_TOP), .BLK_W(BLK_W)
    ) u_map (
        .blk_i(req_block_i), .outer_o(blk_outer), .bank_o(blk_bank)
    );

    fpg_reset_seq #(
        .RST_MIN_CYC(RST_MIN_CYC), .RST_RECOVER_CYC(RST_RECOVER_CYC)
    ) u_rst (
        .clk(clk), .rst_n(rst_n), .rp_low_i(rp_low), .hold_o(rst_hold)
    );

    assign blk_prot = prot_bits_i[req_block_i];

    always_comb begin
        st_d        = st_q;
        st_d.busy   = eng_busy_i && !eng_suspend_i;
        st_d.bank   = eng_bank_i;
        st_d.bypass = wp_elev;
        st_d.res    = RES_NONE;
        if (req_valid_i) begin
            if (rst_hold) begin
                st_d.res = RES_HOLD;
            end else if (req_write_i) begin
                if (blk_outer && wp_low) begin
                    st_d.res = RES_DROP;
                end else if (blk_prot && !rp_elev) begin
                    st_d.res = RES_DROP;
                end else begin
                    st_d.res = RES_GO;
                end
            end else begin
                if (st_q.busy && (st_q.bank == blk_bank)) begin
                    st_d.res = RES_STATUS;
                end else begin
                    st_d.res = RES_ARRAY;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{res: RES_NONE, busy: 1'b0, bank: 1'b0, bypass: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_code_o = st_q.res;
    assign ready_o    = !st_q.busy && !rst_hold;
    assign bypass_o   = st_q.bypass;

    // R1
    wp_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && req_write_i && blk_outer && wp_low && !rst_hold
        |=> res_code_o == RES_DROP)
        else $error("outer boot block write passed while write-protect low");

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && rst_hold |=> res_code_o == RES_HOLD)
        else $error("request served during reset hold");

    // R10
    busy_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i && !req_write_i && !rst_hold && eng_busy_i && !eng_suspend_i
        && $stable(eng_bank_i) && $past(eng_busy_i && !eng_suspend_i)
        && (eng_bank_i == blk_bank)
        |=> res_code_o == RES_STATUS)
        else $error("read of busy bank returned array data");

    // R6
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wp_elev |=> bypass_o)
        else $error("bypass mode not entered on elevated write-protect");

    // R11
    idle_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> res_code_o == RES_NONE)
        else $error("result produced without a request");
endmodule

// File: tb/fpg_prot_gate_tb.sv
module fpg_prot_gate_tb_top;
    localparam int NB  = 16;
    localparam int BW  = 4;
    localparam int MIN = 8;
    localparam int REC = 12;

    localparam int C_NONE = 0, C_ARRAY = 1, C_STATUS = 2, C_GO = 3, C_DROP = 4, C_HOLD = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NB-1:0] prot_bits = '0;
    logic [1:0]    wp_code = 2'b01;
    logic [1:0]    rp_code = 2'b01;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [BW-1:0] req_block = '0;
    logic          eng_busy = 1'b0, eng_suspend = 1'b0, eng_bank = 1'b0;
    logic [2:0]    res_t, res_b;
    logic          ready_t, ready_b, bypass_t, bypass_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    fpg_prot_gate #(.NB_BLOCKS(NB), .BOOT_TOP(1'b1), .RST_MIN_CYC(MIN), .RST_RECOVER_CYC(REC)) dut_i (
        .clk(clk), .rst_n(rst_n), .prot_bits_i(prot_bits), .wp_code_i(wp_code), .rp_code_i(rp_code),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_block_i(req_block),
        .eng_busy_i(eng_busy), .eng_suspend_i(eng_suspend), .eng_bank_i(eng_bank),
        .res_code_o(res_t), .ready_o(ready_t), .bypass_o(bypass_t));

    fpg_prot_gate #(.NB_BLOCKS(NB), .BOOT_TOP(1'b0), .RST_MIN_CYC(MIN), .RST_RECOVER_CYC(REC)) dut_b (
        .clk(clk), .rst_n(rst_n), .prot_bits_i(prot_bits), .wp_code_i(wp_code), .rp_code_i(rp_code),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_block_i(req_block),
        .eng_busy_i(eng_busy), .eng_suspend_i(eng_suspend), .eng_bank_i(eng_bank),
        .res_code_o(res_b), .ready_o(ready_b), .bypass_o(bypass_b));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit is_outer(input int b, input bit top);
        return top ? (b >= NB - 2) : (b < 2);
    endfunction

    function automatic int bank_of(input int b, input bit top);
        if (top) return (b >= NB - NB / 4) ? 0 : 1;
        return (b < NB / 4) ? 0 : 1;
    endfunction

    function automatic int exp_write(input int b, input bit top, input int wp, input bit tu, input bit pb);
        if (is_outer(b, top) && wp == 0) return C_DROP;
        if (pb && !tu) return C_DROP;
        return C_GO;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 reset res top", res_t, C_NONE);
        chk("R11 reset res bottom", res_b, C_NONE);
        chk("R9 reset ready", ready_t, 1);
        chk("R6 reset bypass", bypass_t, 0);

        // write sweep: R1 R2 R3 R4 R5 R6
        for (int pb = 0; pb < 2; pb++) begin
            for (int wp = 0; wp < 3; wp++) begin
                for (int tu = 0; tu < 2; tu++) begin
                    for (int b = 0; b < NB; b++) begin
                        prot_bits = pb[0] ? '1 : '0;
                        wp_code   = (wp == 0) ? 2'b00 : (wp == 1) ? 2'b01 : 2'b10;
                        rp_code   = tu[0] ? 2'b11 : 2'b01;
                        req_valid = 1'b1;
                        req_write = 1'b1;
                        req_block = BW'(b);
                        @(negedge clk);
                        chk(is_outer(b, 1'b1) ? (wp == 0 ? "R1 top" : "R2 top") : (tu[0] ? "R3 top" : "R4 top"),
                            res_t, exp_write(b, 1'b1, wp, tu[0], pb[0]));
                        chk("R5 bottom boot", res_b, exp_write(b, 1'b0, wp, tu[0], pb[0]));
                        chk("R6 bypass", bypass_t, (wp == 2) ? 1 : 0);
                    end
                end
            end
        end

        // mixed pattern: R4
        prot_bits = 16'hA5C3;
        wp_code = 2'b01;
        rp_code = 2'b01;
        for (int b = 0; b < NB; b++) begin
            req_block = BW'(b);
            @(negedge clk);
            chk("R4 mixed top", res_t, prot_bits[b] ? C_DROP : C_GO);
            chk("R4 mixed bottom", res_b, prot_bits[b] ? C_DROP : C_GO);
        end

        // idle: R11
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 idle top", res_t, C_NONE);
        chk("R11 idle bottom", res_b, C_NONE);

        // read sweep: R9 R10 R5
        for (int bz = 0; bz < 2; bz++) begin
            for (int sp = 0; sp < 2; sp++) begin
                for (int eb = 0; eb < 2; eb++) begin
                    eng_busy = bz[0];
                    eng_suspend = sp[0];
                    eng_bank = eb[0];
                    req_valid = 1'b0;
                    @(negedge clk);
                    chk("R9 ready", ready_t, (bz == 1 && sp == 0) ? 0 : 1);
                    for (int b = 0; b < NB; b++) begin
                        req_valid = 1'b1;
                        req_write = 1'b0;
                        req_block = BW'(b);
                        @(negedge clk);
                        chk("R10 read top", res_t,
                            (bz == 1 && sp == 0 && bank_of(b, 1'b1) == eb) ? C_STATUS : C_ARRAY);
                        chk("R10 read bottom", res_b,
                            (bz == 1 && sp == 0 && bank_of(b, 1'b0) == eb) ? C_STATUS : C_ARRAY);
                    end
                end
            end
        end
        eng_busy = 1'b0;
        eng_suspend = 1'b0;
        req_valid = 1'b0;
        prot_bits = '0;
        @(negedge clk);

        // short reset pulse: R7
        for (int i = 0; i < MIN - 1; i++) begin
            rp_code = 2'b00;
            @(negedge clk);
            chk("R7 short pulse ready", ready_t, 1);
        end
        rp_code = 2'b01;
        req_valid = 1'b1;
        req_write = 1'b1;
        req_block = 4'd5;
        @(negedge clk);
        chk("R7 after short pulse", res_t, C_GO);
        req_valid = 1'b0;
        @(negedge clk);

        // full reset pulse: R7 R8
        for (int i = 0; i < MIN; i++) begin
            rp_code = 2'b00;
            @(negedge clk);
            chk("R7 long pulse ready", ready_t, (i == MIN - 1) ? 0 : 1);
        end
        rp_code = 2'b01;
        req_valid = 1'b1;
        req_write = 1'b1;
        req_block = 4'd5;
        for (int k = 0; k <= REC + 1; k++) begin
            @(negedge clk);
            chk("R8 hold result", res_t, (k <= REC) ? C_HOLD : C_GO);
            chk("R8 hold ready", ready_t, (k >= REC) ? 1 : 0);
        end
        req_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule